// File: doc/BRIEF.md
# Transmit Buffer Commit Engine

This block holds one transmit packet buffer behind a small memory-mapped register port and replays its contents onto an AXI4-Stream output. Software first reads a descriptor word that tells it where the buffer sits in the register window and how many bytes it can hold. It then writes the packet into the buffer window one stream-width word at a time. Finally it writes the packet length to a commit register.

Nothing appears on the stream until that commit. A commit is accepted only when the engine is idle and the length lies between 1 and the buffer capacity. The engine then emits the buffer from its first byte onward, one word per beat and in byte order. The beat holding the last byte carries `tx_tlast`, and `tx_tkeep` clears the lanes past the end of the packet.

While a packet is in flight, both the buffer contents and the engine state are frozen. Further commits and buffer writes are dropped, so a stalled beat never changes under backpressure.

Top module: `txc_engine`

## Requirements
- R1: Reading offset 0x1010 returns, with `reg_rd_valid` high one cycle after `reg_rd_en`, a descriptor whose bits [15:0] hold the buffer address (default 0x0200, a multiple of the stream width in bytes) and whose bits [31:16] hold the capacity in bytes (default 256). A read of any other offset returns zero.
- R2: A write at 0x100000 + buffer address + 4·k stores packet bytes 4·k to 4·k+3 under the byte strobes, with byte 4·k+i taken from bits [8i+7:8i].
- R3: A write of a length to offset 0x1018, with the length in bits [15:0], is a commit. An accepted commit raises `tx_tvalid` in the cycle after the write. Before that, `tx_tvalid` stays low.
- R4: The stream carries the packet bytes in order, four per beat, on the same lanes they were written to. `tx_tkeep` is all ones on every beat except the final one. On the final beat, only the low (length mod 4) bits of `tx_tkeep` are set, or all four bits when the remainder is zero.
- R5: `tx_tlast` is high only on the beat that holds the final byte. `tx_tvalid` is low in the cycle after that beat is accepted.
- R6: While `tx_tvalid` is high and `tx_tready` is low, the beat's data, keep and last stay unchanged, and no byte is skipped.
- R7: A commit whose length is zero, or larger than the capacity, is ignored and nothing is streamed. A length equal to the capacity is streamed in full.
- R8: A commit that arrives while a packet is streaming is ignored. This includes a commit in the same cycle as the final beat's handshake.
- R9: Buffer writes made while a packet is streaming are ignored, and the stored bytes keep their earlier values.
- R10: During reset `tx_tvalid` and `reg_rd_valid` are low, and `tx_tvalid` stays low whenever no committed transfer is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_addr | input | 21 | Register write byte offset |
| reg_wr_data | input | 32 | Register write data |
| reg_wr_strb | input | 4 | Byte-lane enables for buffer writes |
| reg_rd_en | input | 1 | Register read strobe |
| reg_rd_addr | input | 21 | Register read byte offset |
| reg_rd_valid | output | 1 | Read data valid, one cycle after the strobe |
| reg_rd_data | output | 32 | Read data |
| tx_tvalid | output | 1 | Stream beat valid |
| tx_tready | input | 1 | Stream sink ready |
| tx_tdata | output | 32 | Stream beat data, byte 0 in bits [7:0] |
| tx_tkeep | output | 4 | Stream byte enables |
| tx_tlast | output | 1 | Final beat of the packet |

## Verification
Two functions can land in the same cycle: the handshake of the final beat, which returns the engine to idle, and a new commit written through the register port. The bench provokes this by driving a second commit in exactly the cycle where it sees the final beat with `tx_tready` high. It judges the outcome by requiring `tx_tvalid` to stay low in the following cycles. The same test is run with a commit and with a buffer write injected during a stalled beat. The buffer's earlier contents are then read back through a fresh commit.

// File: rtl/txc_pkg.sv
package txc_pkg;

   // register map offsets (byte addresses on the register port)
   localparam int unsigned TXC_DESC_OFS   = 32'h0000_1010;
   localparam int unsigned TXC_COMMIT_OFS = 32'h0000_1018;
   localparam int unsigned TXC_WIN_BASE   = 32'h0010_0000;

   typedef enum logic [0:0] {
      TXC_IDLE   = 1'b0,
      TXC_STREAM = 1'b1
   } txc_state_e;

endpackage

// File: rtl/txc_regdec.sv
module txc_regdec #(
   parameter int DATA_BYTES = 4,
   parameter int BUF_BEATS  = 64,
   parameter int BUF_ADDR   = 'h200,
   parameter int LEN_W      = 16,
   parameter int REG_AW     = 21,
   localparam int REG_DW    = DATA_BYTES * 8,
   localparam int LANE_W    = $clog2(DATA_BYTES),
   localparam int IDX_W     = $clog2(BUF_BEATS)
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  wr_en,
   input  logic [REG_AW-1:0]     wr_addr,
   input  logic [REG_DW-1:0]     wr_data,
   input  logic [DATA_BYTES-1:0] wr_strb,
   input  logic                  rd_en,
   input  logic [REG_AW-1:0]     rd_addr,
   input  logic                  busy,
   output logic                  buf_we,
   output logic [IDX_W-1:0]      buf_widx,
   output logic [REG_DW-1:0]     buf_wdata,
   output logic [DATA_BYTES-1:0] buf_wstrb,
   output logic                  commit_req,
   output logic [LEN_W-1:0]      commit_len,
   output logic                  rd_valid,
   output logic [REG_DW-1:0]     rd_data
);
   localparam int BUF_BYTES = DATA_BYTES * BUF_BEATS;
   localparam logic [REG_AW-1:0] WIN_LO   = REG_AW'(txc_pkg::TXC_WIN_BASE + BUF_ADDR);
   localparam logic [REG_AW-1:0] WIN_HI   = REG_AW'(txc_pkg::TXC_WIN_BASE + BUF_ADDR + BUF_BYTES);
   localparam logic [REG_AW-1:0] DESC_A   = REG_AW'(txc_pkg::TXC_DESC_OFS);
   localparam logic [REG_AW-1:0] COMMIT_A = REG_AW'(txc_pkg::TXC_COMMIT_OFS);
   localparam logic [REG_DW-1:0] DESC_VAL = REG_DW'({16'(BUF_BYTES), 16'(BUF_ADDR)});

   logic              win_hit;
   logic [REG_AW-1:0] win_off;
   logic [REG_DW-1:0] rd_next;

   assign win_hit   = (wr_addr >= WIN_LO) && (wr_addr < WIN_HI);
   assign win_off   = wr_addr - WIN_LO;
   assign buf_widx  = win_off[LANE_W +: IDX_W];
   assign buf_we    = wr_en && win_hit && !busy;
   assign buf_wdata = wr_data;
   assign buf_wstrb = wr_strb;

   assign commit_req = wr_en && (wr_addr == COMMIT_A);
   assign commit_len = wr_data[LEN_W-1:0];

   logic unused_regdec;
   assign unused_regdec = ^{win_off[LANE_W-1:0], win_off[REG_AW-1:LANE_W+IDX_W],
                            wr_data[REG_DW-1:LEN_W]};

   assign rd_next = (rd_addr == DESC_A) ? DESC_VAL : '0;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rd_valid <= 1'b0;
         rd_data  <= '0;
      end else begin
         rd_valid <= rd_en;
         if (rd_en) rd_data <= rd_next;
      end
   end
endmodule

// File: rtl/txc_buf.sv
module txc_buf #(
   parameter int DATA_BYTES = 4,
   parameter int BUF_BEATS  = 64,
   localparam int REG_DW    = DATA_BYTES * 8,
   localparam int IDX_W     = $clog2(BUF_BEATS)
) (
   input  logic                  clk,
   input  logic                  we,
   input  logic [IDX_W-1:0]      widx,
   input  logic [REG_DW-1:0]     wdata,
   input  logic [DATA_BYTES-1:0] wstrb,
   input  logic [IDX_W-1:0]      ridx,
   output logic [REG_DW-1:0]     rword
);
   for (genvar ln = 0; ln < DATA_BYTES; ln++) begin : g_lane
      logic [7:0] lane_mem [BUF_BEATS];

      always_ff @(posedge clk) begin
         if (we && wstrb[ln]) lane_mem[widx] <= wdata[8*ln +: 8];
      end

      assign rword[8*ln +: 8] = lane_mem[ridx];
   end
endmodule

// File: rtl/txc_sequencer.sv
module txc_sequencer #(
   parameter int DATA_BYTES = 4,
   parameter int BUF_BEATS  = 64,
   parameter int LEN_W      = 16,
   localparam int REG_DW    = DATA_BYTES * 8,
   localparam int LANE_W    = $clog2(DATA_BYTES),
   localparam int IDX_W     = $clog2(BUF_BEATS)
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  commit_req,
   input  logic [LEN_W-1:0]      commit_len,
   output logic                  busy,
   output logic [IDX_W-1:0]      rd_idx,
   input  logic [REG_DW-1:0]     word,
   input  logic                  tready,
   output logic                  tvalid,
   output logic [REG_DW-1:0]     tdata,
   output logic [DATA_BYTES-1:0] tkeep,
   output logic                  tlast
);
   import txc_pkg::*;

   localparam int BUF_BYTES = DATA_BYTES * BUF_BEATS;
   localparam logic [LEN_W:0] CAP = (LEN_W+1)'(BUF_BYTES);

   txc_state_e         state_q;
   logic [IDX_W-1:0]   beat_q;
   logic [IDX_W-1:0]   last_q;
   logic [LANE_W-1:0]  tail_q;
   logic [LEN_W-1:0]   len_m1;
   logic               accept;
   logic               at_last;
   logic [DATA_BYTES-1:0] tail_keep;

   assign busy    = (state_q == TXC_STREAM);
   assign len_m1  = commit_len - LEN_W'(1);
   assign accept  = commit_req && !busy && (commit_len != '0) &&
                    ({1'b0, commit_len} <= CAP);
   assign at_last = (beat_q == last_q);

   logic unused_seq;
   assign unused_seq = ^{len_m1[LANE_W-1:0], len_m1[LEN_W-1:LANE_W+IDX_W]};

   for (genvar ln = 0; ln < DATA_BYTES; ln++) begin : g_keep
      assign tail_keep[ln] = (tail_q == '0) || ({1'b0, tail_q} > (LANE_W+1)'(ln));
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= TXC_IDLE;
         beat_q  <= '0;
         last_q  <= '0;
         tail_q  <= '0;
      end else begin
         unique case (state_q)
            TXC_IDLE: begin
               if (accept) begin
                  state_q <= TXC_STREAM;
                  beat_q  <= '0;
                  last_q  <= len_m1[LANE_W +: IDX_W];
                  tail_q  <= commit_len[LANE_W-1:0];
               end
            end
            TXC_STREAM: begin
               if (tready) begin
                  if (at_last) state_q <= TXC_IDLE;
                  else         beat_q  <= beat_q + IDX_W'(1);
               end
            end
            default: state_q <= TXC_IDLE;
         endcase
      end
   end

   assign rd_idx = beat_q;
   assign tvalid = busy;
   assign tlast  = busy && at_last;
   assign tdata  = busy ? word : '0;
   assign tkeep  = !busy ? '0 : (at_last ? tail_keep : '1);
endmodule

// File: rtl/txc_engine.sv
module txc_engine #(
   parameter int DATA_BYTES = 4,
   parameter int BUF_BEATS  = 64,
   parameter int BUF_ADDR   = 'h200,
   parameter int LEN_W      = 16,
   parameter int REG_AW     = 21,
   localparam int REG_DW    = DATA_BYTES * 8,
   localparam int IDX_W     = $clog2(BUF_BEATS),
   localparam int LANE_W    = $clog2(DATA_BYTES)
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  reg_wr_en,
   input  logic [REG_AW-1:0]     reg_wr_addr,
   input  logic [REG_DW-1:0]     reg_wr_data,
   input  logic [DATA_BYTES-1:0] reg_wr_strb,
   input  logic                  reg_rd_en,
   input  logic [REG_AW-1:0]     reg_rd_addr,
   output logic                  reg_rd_valid,
   output logic [REG_DW-1:0]     reg_rd_data,
   output logic                  tx_tvalid,
   input  logic                  tx_tready,
   output logic [REG_DW-1:0]     tx_tdata,
   output logic [DATA_BYTES-1:0] tx_tkeep,
   output logic                  tx_tlast
);
   localparam int BUF_BYTES = DATA_BYTES * BUF_BEATS;

   // elaboration-time parameter checks
   if (DATA_BYTES < 4 || (1 << LANE_W) != DATA_BYTES) begin : g_bad_width
      $error("DATA_BYTES must be a power of two, at least 4");
   end
   if (BUF_BEATS < 2 || (1 << IDX_W) != BUF_BEATS) begin : g_bad_depth
      $error("BUF_BEATS must be a power of two, at least 2");
   end
   if (LANE_W + IDX_W >= LEN_W || BUF_BYTES > 65535) begin : g_bad_len
      $error("buffer capacity must fit the length and descriptor fields");
   end
   if ((BUF_ADDR % DATA_BYTES) != 0 || BUF_ADDR > 65535) begin : g_bad_addr
      $error("BUF_ADDR must be stream-width aligned and fit 16 bits");
   end
   if (longint'(txc_pkg::TXC_WIN_BASE) + BUF_ADDR + BUF_BYTES > (longint'(1) << REG_AW)) begin : g_bad_aw
      $error("REG_AW too narrow for the buffer window");
   end

   logic                  busy;
   logic                  buf_we;
   logic [IDX_W-1:0]      buf_widx;
   logic [REG_DW-1:0]     buf_wdata;
   logic [DATA_BYTES-1:0] buf_wstrb;
   logic                  commit_req;
   logic [LEN_W-1:0]      commit_len;
   logic [IDX_W-1:0]      rd_idx;
   logic [REG_DW-1:0]     rd_word;

   txc_regdec #(
      .DATA_BYTES(DATA_BYTES), .BUF_BEATS(BUF_BEATS), .BUF_ADDR(BUF_ADDR),
      .LEN_W(LEN_W), .REG_AW(REG_AW)
   ) u_regdec (
      .clk(clk), .rst_n(rst_n),
      .wr_en(reg_wr_en), .wr_addr(reg_wr_addr), .wr_data(reg_wr_data), .wr_strb(reg_wr_strb),
      .rd_en(reg_rd_en), .rd_addr(reg_rd_addr), .busy(busy),
      .buf_we(buf_we), .buf_widx(buf_widx), .buf_wdata(buf_wdata), .buf_wstrb(buf_wstrb),
      .commit_req(commit_req), .commit_len(commit_len),
      .rd_valid(reg_rd_valid), .rd_data(reg_rd_data)
   );

   txc_buf #(
      .DATA_BYTES(DATA_BYTES), .BUF_BEATS(BUF_BEATS)
   ) u_buf (
      .clk(clk), .we(buf_we), .widx(buf_widx), .wdata(buf_wdata), .wstrb(buf_wstrb),
      .ridx(rd_idx), .rword(rd_word)
   );

   txc_sequencer #(
      .DATA_BYTES(DATA_BYTES), .BUF_BEATS(BUF_BEATS), .LEN_W(LEN_W)
   ) u_seq (
      .clk(clk), .rst_n(rst_n),
      .commit_req(commit_req), .commit_len(commit_len), .busy(busy),
      .rd_idx(rd_idx), .word(rd_word), .tready(tx_tready),
      .tvalid(tx_tvalid), .tdata(tx_tdata), .tkeep(tx_tkeep), .tlast(tx_tlast)
   );
endmodule

// File: rtl/txc_engine_chk.sv
module txc_engine_chk #(
   parameter int DATA_BYTES = 4,
   parameter int REG_AW     = 21,
   localparam int REG_DW    = DATA_BYTES * 8
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic                  reg_wr_en,
   input logic [REG_AW-1:0]     reg_wr_addr,
   input logic                  reg_rd_en,
   input logic                  reg_rd_valid,
   input logic                  tx_tvalid,
   input logic                  tx_tready,
   input logic [REG_DW-1:0]     tx_tdata,
   input logic [DATA_BYTES-1:0] tx_tkeep,
   input logic                  tx_tlast
);
   localparam logic [REG_AW-1:0] COMMIT_A = REG_AW'(txc_pkg::TXC_COMMIT_OFS);

   // R1: read strobe is answered exactly one cycle later
   p_rd_answer_r1: assert property (@(posedge clk) disable iff (!rst_n)
      reg_rd_en |=> reg_rd_valid);
   p_rd_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !reg_rd_en |=> !reg_rd_valid);

   // R3: a transfer only begins right after a commit write
   p_start_after_commit_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(tx_tvalid) |-> $past(reg_wr_en && (reg_wr_addr == COMMIT_A)));

   // R4: non-final beats carry every lane; lane 0 is always kept
   p_full_keep_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_tvalid && !tx_tlast) |-> (&tx_tkeep));
   p_lane0_kept_r4: assert property (@(posedge clk) disable iff (!rst_n)
      tx_tvalid |-> tx_tkeep[0]);

   // R5 / R8: final handshake leaves the stream idle, even with a commit in that cycle
   p_idle_after_last_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_tvalid && tx_tready && tx_tlast) |=> !tx_tvalid);

   // R6: a stalled beat is held unchanged
   p_hold_on_stall_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_tvalid && !tx_tready) |=>
         (tx_tvalid && $stable(tx_tdata) && $stable(tx_tkeep) && $stable(tx_tlast)));
endmodule

bind txc_engine txc_engine_chk #(
   .DATA_BYTES(DATA_BYTES), .REG_AW(REG_AW)
) u_chk (
   .clk(clk), .rst_n(rst_n),
   .reg_wr_en(reg_wr_en), .reg_wr_addr(reg_wr_addr),
   .reg_rd_en(reg_rd_en), .reg_rd_valid(reg_rd_valid),
   .tx_tvalid(tx_tvalid), .tx_tready(tx_tready), .tx_tdata(tx_tdata),
   .tx_tkeep(tx_tkeep), .tx_tlast(tx_tlast)
);

// File: tb/txc_engine_tb_top.sv
module txc_engine_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int DB         = 4;
   localparam int AW         = 21;
   localparam int CAP        = 256;
   localparam int BUF_ADDR   = 'h200;
   localparam int WIN        = 'h100000 + BUF_ADDR;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            reg_wr_en = 1'b0;
   logic [AW-1:0]   reg_wr_addr = '0;
   logic [31:0]     reg_wr_data = '0;
   logic [DB-1:0]   reg_wr_strb = '0;
   logic            reg_rd_en = 1'b0;
   logic [AW-1:0]   reg_rd_addr = '0;
   logic            reg_rd_valid;
   logic [31:0]     reg_rd_data;
   logic            tx_tvalid;
   logic            tx_tready = 1'b0;
   logic [31:0]     tx_tdata;
   logic [DB-1:0]   tx_tkeep;
   logic            tx_tlast;

   int n_chk = 0;
   int n_bad = 0;
   bit finished = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   txc_engine dut_i (
      .clk(clk), .rst_n(rst_n),
      .reg_wr_en(reg_wr_en), .reg_wr_addr(reg_wr_addr), .reg_wr_data(reg_wr_data),
      .reg_wr_strb(reg_wr_strb), .reg_rd_en(reg_rd_en), .reg_rd_addr(reg_rd_addr),
      .reg_rd_valid(reg_rd_valid), .reg_rd_data(reg_rd_data),
      .tx_tvalid(tx_tvalid), .tx_tready(tx_tready), .tx_tdata(tx_tdata),
      .tx_tkeep(tx_tkeep), .tx_tlast(tx_tlast)
   );

   task automatic check(input bit ok, input string req, input string what,
                        input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
      end
   endtask

   function automatic logic [7:0] pbyte(input int seed, input int i);
      return 8'(seed * 13 + i * 29 + (i >> 5));
   endfunction

   function automatic logic [DB-1:0] exp_keep(input int len, input bit last);
      int rem = len % DB;
      if (!last || rem == 0) return '1;
      return DB'((1 << rem) - 1);
   endfunction

   // all driving and sampling is done at the falling edge
   task automatic reg_write(input int addr, input logic [31:0] data, input logic [DB-1:0] strb);
      reg_wr_en = 1'b1; reg_wr_addr = AW'(addr); reg_wr_data = data; reg_wr_strb = strb;
      @(negedge clk);
      reg_wr_en = 1'b0;
   endtask

   task automatic load_pkt(input int len, input int seed);
      for (int w = 0; w < (len + DB - 1) / DB; w++) begin
         logic [31:0] word;
         for (int b = 0; b < DB; b++) word[8*b +: 8] = pbyte(seed, w*DB + b);
         reg_write(WIN + w*DB, word, '1);
      end
   endtask

   // collect one packet; inject: 0 none, 1 commit mid-stream, 2 buffer write mid-stream
   // edge_commit: drive a commit in the cycle of the final handshake
   task automatic collect(input int len, input int seed, input bit stall,
                          input int inject, input bit edge_commit, input string req);
      int nb = (len + DB - 1) / DB;
      int b = 0;
      int cyc = 0;
      int bad_data = 0, bad_keep = 0, bad_last = 0, bad_hold = 0, dropped = 0;
      bit done = 1'b0;
      bit held = 1'b0;
      logic [31:0] h_data = '0;
      logic [DB-1:0] h_keep = '0;
      logic h_last = 1'b0;
      while (!done && cyc < 3000) begin
         bit rdy = stall ? ((cyc % 3) != 1) : 1'b1;
         tx_tready = rdy;
         reg_wr_en = 1'b0;
         if (cyc == 1 && inject == 1) begin
            reg_wr_en = 1'b1; reg_wr_addr = AW'('h1018); reg_wr_data = 32'd4; reg_wr_strb = '1;
         end
         if (cyc == 1 && inject == 2) begin
            reg_wr_en = 1'b1; reg_wr_addr = AW'(WIN); reg_wr_data = 32'hDEAD_BEEF; reg_wr_strb = '1;
         end
         if (!tx_tvalid) dropped++;
         else begin
            if (held && (tx_tdata != h_data || tx_tkeep != h_keep || tx_tlast != h_last)) bad_hold++;
            if (rdy) begin
               bit lst = (b == nb - 1);
               logic [DB-1:0] ek = exp_keep(len, lst);
               if (tx_tkeep != ek) bad_keep++;
               if (tx_tlast != lst) bad_last++;
               for (int k = 0; k < DB; k++)
                  if (ek[k] && tx_tdata[8*k +: 8] != pbyte(seed, b*DB + k)) bad_data++;
               if (lst) begin
                  done = 1'b1;
                  if (edge_commit) begin
                     reg_wr_en = 1'b1; reg_wr_addr = AW'('h1018);
                     reg_wr_data = 32'd8; reg_wr_strb = '1;
                  end
               end
               b++;
               held = 1'b0;
            end else begin
               held = 1'b1; h_data = tx_tdata; h_keep = tx_tkeep; h_last = tx_tlast;
            end
         end
         @(negedge clk);
         cyc++;
      end
      reg_wr_en = 1'b0;
      tx_tready = 1'b0;
      check(done && dropped == 0, req, "packet completed without gaps", dropped, 0);
      check(bad_data == 0, "R4", $sformatf("byte order (%s)", req), bad_data, 0);
      check(bad_keep == 0, "R4", $sformatf("keep pattern (%s)", req), bad_keep, 0);
      check(bad_last == 0, "R5", $sformatf("last placement (%s)", req), bad_last, 0);
      if (stall) check(bad_hold == 0, "R6", "stalled beat held", bad_hold, 0);
      check(!tx_tvalid, "R5", "valid low after final handshake", tx_tvalid, 0);
   endtask

   task automatic expect_quiet(input int cycles, input string req);
      int seen = 0;
      tx_tready = 1'b1;
      for (int i = 0; i < cycles; i++) begin
         if (tx_tvalid) seen++;
         @(negedge clk);
      end
      tx_tready = 1'b0;
      check(seen == 0, req, "no stream activity", seen, 0);
   endtask

   task automatic send(input int len, input int seed, input bit stall, input string req);
      load_pkt(len, seed);
      check(!tx_tvalid, "R3", "nothing streams before commit", tx_tvalid, 0);
      reg_write('h1018, 32'(len), '1);
      check(tx_tvalid, "R3", "valid one cycle after commit", tx_tvalid, 1);
      collect(len, seed, stall, 0, 1'b0, req);
   endtask

   task automatic t_reset;
      @(negedge clk); @(negedge clk);
      check(!tx_tvalid, "R10", "tvalid in reset", tx_tvalid, 0);
      check(!reg_rd_valid, "R10", "rd_valid in reset", reg_rd_valid, 0);
      rst_n = 1'b1;
      @(negedge clk);
      expect_quiet(3, "R10");
   endtask

   task automatic t_descriptor;
      reg_rd_en = 1'b1; reg_rd_addr = AW'('h1010);
      @(negedge clk);
      reg_rd_en = 1'b0;
      check(reg_rd_valid, "R1", "descriptor read valid", reg_rd_valid, 1);
      check(reg_rd_data == {16'(CAP), 16'(BUF_ADDR)}, "R1", "descriptor value",
            reg_rd_data, {16'(CAP), 16'(BUF_ADDR)});
      check(reg_rd_data[15:0] % DB == 0, "R1", "buffer address aligned", reg_rd_data[15:0] % DB, 0);
      reg_rd_en = 1'b1; reg_rd_addr = AW'('h1018);
      @(negedge clk);
      reg_rd_en = 1'b0;
      check(reg_rd_valid && reg_rd_data == 0, "R1", "other offset reads zero", reg_rd_data, 0);
      @(negedge clk);
      check(!reg_rd_valid, "R1", "rd_valid drops", reg_rd_valid, 0);
   endtask

   task automatic t_lengths;
      send(1, 3, 1'b0, "R2");
      send(4, 5, 1'b0, "R2");
      send(7, 9, 1'b0, "R4");
      send(13, 11, 1'b1, "R6");
   endtask

   task automatic t_bounds;
      reg_write('h1018, 32'd257, '1);
      expect_quiet(4, "R7");
      reg_write('h1018, 32'd0, '1);
      expect_quiet(4, "R7");
      send(CAP, 21, 1'b1, "R7");
   endtask

   task automatic t_busy_commit;
      load_pkt(12, 31);
      reg_write('h1018, 32'd12, '1);
      collect(12, 31, 1'b1, 1, 1'b0, "R8");
      expect_quiet(4, "R8");
   endtask

   task automatic t_edge_commit;
      load_pkt(8, 41);
      reg_write('h1018, 32'd8, '1);
      collect(8, 41, 1'b0, 0, 1'b1, "R8");
      expect_quiet(4, "R8");
   endtask

   task automatic t_frozen_buffer;
      load_pkt(12, 51);
      reg_write('h1018, 32'd12, '1);
      collect(12, 51, 1'b1, 2, 1'b0, "R9");
      reg_write('h1018, 32'd4, '1);
      collect(4, 51, 1'b0, 0, 1'b0, "R9");
   endtask

   initial begin
      @(negedge clk);
      t_reset;
      t_descriptor;
      t_lengths;
      t_bounds;
      t_busy_commit;
      t_edge_commit;
      t_frozen_buffer;
      if (!finished) begin
         finished = 1'b1;
         $display("test done: total=%0d bad=%0d", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      #(CLK_PERIOD * 150000);
      if (!finished) begin
         finished = 1'b1;
         n_chk++;
         n_bad++;
         $display("FAIL R10 watchdog: actual=0x0 expected=0x1");
         $display("test done: total=%0d bad=%0d", n_chk, n_bad);
         $finish;
      end
   end
endmodule